// File: doc/BRIEF.md
# Snapshot-Readable Shift FIFO

This block is a synchronous first-in first-out queue with the usual push and pop controls, a head-of-queue output, full and empty status, and a flush request. It also drives a parallel snapshot of every storage slot, each paired with its own valid flag. A consumer can therefore inspect the whole queue in a single cycle without removing anything. Typical uses are scoreboards, match searches across pending requests, and arbiters that must see every waiting entry.

Storage works as a shift register. A pop moves every entry one slot toward slot 0, so slot 0 always holds the oldest item and the snapshot is always ordered oldest-first. Push and pop may both take effect in the same cycle. Every output shows the state at the start of the cycle, and a flush in a cycle overrides any push or pop requested in that cycle. The data width is a parameter. The depth is a parameter that must be a power of two of at least 2; any other depth stops elaboration with an error.

Top module: `snap_fifo`

## Requirements
- R1: A synchronous active-high reset leaves the queue empty. After reset, `not_empty` is 0, `not_full` is 1 and every bit of `snap_valid` is 0.
- R2: `head_data` shows the oldest stored entry. Entries leave the queue in the order they were pushed.
- R3: Slot k of the snapshot, which is bits `[k*DATA_W +: DATA_W]` of `snap_data`, holds the (k+1)-th oldest entry. Slot 0 is the oldest.
- R4: `snap_valid[k]` is 1 exactly when k is less than the current entry count. The valid bits therefore form a thermometer code that starts at bit 0.
- R5: `not_full` is 0 only when the count equals DEPTH. `not_empty` is 0 only when the count is 0.
- R6: All outputs come from registered state. A push, pop or flush requested in a cycle first shows on the outputs after the next rising clock edge.
- R7: A push and a pop together on a queue that is neither empty nor full both take effect. The count stays the same, and the new item lands in slot count-1 after the shift.
- R8: A push is accepted only if the queue was not full at the start of the cycle, even when a pop happens in the same cycle. A pop is accepted only if the queue was not empty at the start of the cycle, even when a push happens in the same cycle.
- R9: A push on its own while full, or a pop on its own while empty, is ignored and leaves the count and every stored entry unchanged.
- R10: A flush empties the queue at the next edge. The count becomes 0 whatever push or pop was requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Push request |
| push_data | input | DATA_W | Item to push |
| pop | input | 1 | Pop request |
| flush | input | 1 | Empty the queue; overrides push and pop |
| head_data | output | DATA_W | Oldest entry |
| not_full | output | 1 | Queue has at least one free slot |
| not_empty | output | 1 | Queue holds at least one entry |
| snap_data | output | DEPTH*DATA_W | All slots, slot 0 in the low bits |
| snap_valid | output | DEPTH | Per-slot valid flags |

## Verification
The bench aims at the boundaries of the count. A push and pop together on a full queue must leave DEPTH-1 entries; a design that reads full after the pop would keep DEPTH and corrupt the last slot. A push and pop together on an empty queue must leave one entry; a design that allowed the pop would stay empty or lose the item. A flush together with a push must give an empty queue, where a wrong priority would leave one entry. Lone pushes while full and lone pops while empty are compared slot by slot. A wrong write index after the shift shows up as a misplaced or duplicated snapshot slot.

// File: rtl/snap_fifo.sv
module snap_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    push,
  input  logic [DATA_W-1:0]       push_data,
  input  logic                    pop,
  input  logic                    flush,
  output logic [DATA_W-1:0]       head_data,
  output logic                    not_full,
  output logic                    not_empty,
  output logic [DEPTH*DATA_W-1:0] snap_data,
  output logic [DEPTH-1:0]        snap_valid
);
  localparam int  CNT_W    = $clog2(DEPTH) + 1;
  localparam int  TOTAL_W  = DEPTH * DATA_W;
  localparam bit  DEPTH_OK = (DEPTH >= 2) && ((DEPTH & (DEPTH - 1)) == 0);

  if (!DEPTH_OK) begin : g_bad_depth
    $error("snap_fifo: DEPTH must be a power of two, at least 2");
  end

  logic [CNT_W-1:0]   cnt, cnt_nxt, wr_idx;
  logic [TOTAL_W-1:0] store, shifted, store_nxt;
  logic               take_push, take_pop;

  assign take_push = push && (cnt != CNT_W'(DEPTH));
  assign take_pop  = pop  && (cnt != '0);
  assign wr_idx    = cnt - CNT_W'(take_pop);
  assign cnt_nxt   = cnt + CNT_W'(take_push) - CNT_W'(take_pop);
  assign shifted   = {store[TOTAL_W-1 -: DATA_W], store[TOTAL_W-1:DATA_W]};

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign store_nxt[g*DATA_W +: DATA_W] =
      (take_push && wr_idx == CNT_W'(g)) ? push_data :
      take_pop ? shifted[g*DATA_W +: DATA_W] : store[g*DATA_W +: DATA_W];
    assign snap_valid[g] = cnt > CNT_W'(g);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      store <= '0;
    end else if (flush) begin
      cnt   <= '0;
    end else begin
      cnt   <= cnt_nxt;
      store <= store_nxt;
    end
  end

  assign head_data = store[DATA_W-1:0];
  assign snap_data = store;
  assign not_full  = cnt != CNT_W'(DEPTH);
  assign not_empty = cnt != '0;
endmodule

// File: rtl/snap_fifo_chk.sv
module snap_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    push,
  input logic                    pop,
  input logic                    flush,
  input logic [DATA_W-1:0]       head_data,
  input logic                    not_full,
  input logic                    not_empty,
  input logic [DEPTH*DATA_W-1:0] snap_data,
  input logic [DEPTH-1:0]        snap_valid
);
  logic [DEPTH:0] valid_plus;
  assign valid_plus = {1'b0, snap_valid} + (DEPTH+1)'(1);

  AST_THERMO_VALID: assert property (@(posedge clk) disable iff (rst)
    $onehot0(valid_plus)); // R4
  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (rst)
    not_empty == snap_valid[0]); // R5
  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (rst)
    not_full == !snap_valid[DEPTH-1]); // R5
  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (rst)
    flush |=> !not_empty); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (!not_full && push && !pop && !flush) |=> (!not_full && $stable(snap_data))); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (!not_empty && pop && !push && !flush) |=> !not_empty); // R9
  AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (rst)
    (snap_valid[1] && pop && !flush) |=> head_data == $past(snap_data[2*DATA_W-1:DATA_W])); // R2
  AST_PAIR_COUNT: assert property (@(posedge clk) disable iff (rst)
    (not_empty && not_full && push && pop && !flush) |=> $stable(snap_valid)); // R7
endmodule

bind snap_fifo snap_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .push(push), .pop(pop), .flush(flush),
  .head_data(head_data), .not_full(not_full), .not_empty(not_empty),
  .snap_data(snap_data), .snap_valid(snap_valid)
);

// File: tb/test_snap_fifo.sv
`timescale 1ns/1ps
module test_snap_fifo;
  localparam int W = 8;
  localparam int D = 4;

  logic clk = 1'b0, rst = 1'b1, push = 1'b0, pop = 1'b0, flush = 1'b0;
  logic [W-1:0]   push_data = '0;
  logic [W-1:0]   head_data;
  logic           not_full, not_empty;
  logic [D*W-1:0] snap_data;
  logic [D-1:0]   snap_valid;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [W-1:0] model[$];

  always #10 clk = ~clk;

  snap_fifo #(.DATA_W(W), .DEPTH(D)) i_snap_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data), .pop(pop),
    .flush(flush), .head_data(head_data), .not_full(not_full),
    .not_empty(not_empty), .snap_data(snap_data), .snap_valid(snap_valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [D-1:0] exp_valid(input int n);
    logic [D-1:0] v = '0;
    for (int k = 0; k < D; k++) if (k < n) v[k] = 1'b1;
    return v;
  endfunction

  task automatic check_state();
    int n = model.size();
    chk(snap_valid == exp_valid(n), "R4 valid thermometer", snap_valid, exp_valid(n));
    chk(not_empty == (n != 0), "R5 not_empty", not_empty, n != 0);
    chk(not_full == (n != D), "R5 not_full", not_full, n != D);
    if (n > 0) chk(head_data == model[0], "R2 head", head_data, model[0]);
    for (int k = 0; k < n; k++)
      chk(snap_data[k*W +: W] == model[k], "R3 slot order", snap_data[k*W +: W], model[k]);
  endtask

  task automatic model_step(input bit p, input bit q, input bit f, input logic [W-1:0] d);
    int n = model.size();
    if (f) model.delete();
    else begin
      if (q && n > 0) void'(model.pop_front());
      if (p && n < D) model.push_back(d);
    end
  endtask

  task automatic cyc(input bit p, input bit q, input bit f, input logic [W-1:0] d);
    @(negedge clk);
    check_state();
    push = p; pop = q; flush = f; push_data = d;
    @(posedge clk);
    model_step(p, q, f, d);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(not_empty == 1'b0, "R1 reset not_empty", not_empty, 0);
    chk(not_full == 1'b1, "R1 reset not_full", not_full, 1);
    chk(snap_valid == '0, "R1 reset valid", snap_valid, 0);

    push = 1'b1; push_data = 8'hA1;
    #1 chk(not_empty == 1'b0, "R6 no change before edge", not_empty, 0);
    @(posedge clk); model_step(1, 0, 0, 8'hA1);
    @(negedge clk); push = 1'b0;
    chk(not_empty == 1'b1, "R6 visible after edge", not_empty, 1);

    for (int i = 0; i < D - 1; i++) cyc(1, 0, 0, W'(8'hB0 + i));
    cyc(1, 0, 0, 8'hEE);
    cyc(0, 0, 0, 0);
    chk(snap_data[(D-1)*W +: W] == 8'hB2, "R9 push while full ignored", snap_data[(D-1)*W +: W], 8'hB2);
    cyc(1, 1, 0, 8'hCC);
    cyc(0, 0, 0, 0);
    chk(snap_valid == exp_valid(D-1), "R8 push+pop when full drops push", snap_valid, exp_valid(D-1));
    cyc(1, 1, 0, 8'hDD);
    cyc(0, 0, 0, 0);
    chk(snap_data[(D-2)*W +: W] == 8'hDD && snap_valid == exp_valid(D-1),
        "R7 pair write slot count-1", snap_data[(D-2)*W +: W], 8'hDD);
    cyc(1, 0, 1, 8'h55);
    cyc(0, 0, 0, 0);
    chk(not_empty == 1'b0, "R10 flush beats push", not_empty, 0);
    cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 0);
    chk(snap_valid == '0, "R9 pop while empty ignored", snap_valid, 0);
    cyc(1, 1, 0, 8'h77);
    cyc(0, 0, 0, 0);
    chk(snap_valid == exp_valid(1) && head_data == 8'h77, "R8 push+pop when empty drops pop", head_data, 8'h77);

    for (int i = 0; i < 3000; i++) begin
      int phase = (i / 200) % 3;
      int r = $urandom_range(99);
      bit p = (phase == 0) ? (r < 75) : (phase == 1) ? (r < 25) : (r < 50);
      bit q = (phase == 0) ? ($urandom_range(99) < 25) : (phase == 1) ? ($urandom_range(99) < 75) : ($urandom_range(99) < 50);
      bit f = $urandom_range(99) < 2;
      cyc(p, q, f, W'($urandom));
    end
    cyc(0, 0, 0, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule